// File: doc/BRIEF.md
# External Reset Pin Manager

This block owns one shared, active-low reset pad of a chip and runs entirely on the slow clock of the reset controller. After power-on it holds the pad low for a programmable time. It drives the pad low again whenever the reset sequencer asks for a pulse. At all other times it treats the pad as an input. The pad passes through a two-stage synchronizer, and the block reports a user reset when the pad is pulled low from outside.

Configuration selects the pulse length, whether an external low level actually resets the chip, and whether it raises the interrupt line. The status port shows the synchronized pad level and a sticky flag that records any external assertion. A read strobe clears the flag. The block also produces active-low resets for the processor and for the peripherals. These follow the pulse and any enabled user reset.

Top module: `rst_pin_mgr`

## Requirements
- R1: While `rst_n` is low, `pin_drive_low` is 1, `cpu_rst_n` and `periph_rst_n` are 0, `stat_sticky` is 0 and `user_rst_evt` is 0.
- R2: After `rst_n` is released, `pin_drive_low` stays 1 for exactly 2^(`cfg_pulse_len`+1) rising edges. It is 0 after that edge, and the pad is then treated as an input.
- R3: A one-cycle `req_pulse` drives the pad low from the next edge for exactly 2^(`cfg_pulse_len`+1) edges. A request that arrives during a pulse restarts the count.
- R4: `stat_level` shows the pad level delayed by two rising edges (two-flop synchronizer). It is readable at any time.
- R5: With `cfg_urst_en`=1 and the pad low in input mode, `user_rst_evt` is 1 and both reset outputs are 0 from the third edge after the pad falls. They last while the pad stays low.
- R6: With `cfg_urst_en`=0, a low pad leaves `user_rst_evt` at 0 and both resets at 1, but `stat_sticky` is still set.
- R7: `stat_sticky` is set on the third edge after the pad goes low. It clears on the edge where `stat_rd` is 1. When a set and a read fall on the same edge, the set wins.
- R8: `irq` is 1 exactly when `stat_sticky` is 1 and `cfg_irq_en` is 1.
- R9: The block's own drive never sets `stat_sticky` or `user_rst_evt`. This covers the synchronizer latency after the drive is released.
- R10: Both reset outputs are 0 on the edge after any edge where the pad is driven. They return to 1 one edge after the drive ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Power-on reset, active low |
| cfg_pulse_len | input | 4 | Pulse length code, pulse is 2^(code+1) cycles |
| cfg_urst_en | input | 1 | External low level causes a reset |
| cfg_irq_en | input | 1 | External assertion raises irq |
| req_pulse | input | 1 | Pulse request from the reset sequencer |
| pin_in | input | 1 | Pad input level |
| pin_drive_low | output | 1 | 1 drives the pad low |
| stat_rd | input | 1 | Status read strobe, clears sticky flag |
| stat_level | output | 1 | Synchronized pad level |
| stat_sticky | output | 1 | External assertion seen since last read |
| user_rst_evt | output | 1 | User reset event to the sequencer |
| irq | output | 1 | Interrupt line |
| cpu_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |

## Verification
Two functions can act on the same edge: the status read that clears the sticky flag, and a new pad assertion that sets it. The bench pulls the pad low and waits two edges, so the synchronized level is low just before the edge that sets the flag. It raises the read strobe for exactly that edge. The flag must still read 1 afterwards. A later read with the pad high must clear it, which shows the read was not simply ignored.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
    localparam int LEN_W       = 4;
    localparam int CNT_W       = (2 ** LEN_W) + 1;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    typedef struct packed {
        logic                   sticky;
        logic                   evt;
        logic                   cpu_n;
        logic                   periph_n;
        logic [SYNC_STAGES-1:0] guard;
    } mgr_state_t;
endpackage

// File: rtl/rpm_sync.sv
module rpm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rpm_pulse_timer.sv
module rpm_pulse_timer
    import rpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    tmr_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = {{(CNT_W-1){1'b0}}, 1'b1} << (32'(len) + 32'd1);
        st_d  = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == limit - 1'b1) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

    // R3: the count never reaches the programmed limit while driving
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt < limit));
endmodule

// File: rtl/rst_pin_mgr.sv
module rst_pin_mgr
    import rpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_pulse_len,
    input  logic             cfg_urst_en,
    input  logic             cfg_irq_en,
    input  logic             req_pulse,
    input  logic             pin_in,
    output logic             pin_drive_low,
    input  logic             stat_rd,
    output logic             stat_level,
    output logic             stat_sticky,
    output logic             user_rst_evt,
    output logic             irq,
    output logic             cpu_rst_n,
    output logic             periph_rst_n
);
    mgr_state_t st_d, st_q;
    logic       drive;
    logic       pin_sync;
    logic       masked;
    logic       low_seen;

    rpm_pulse_timer u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_pulse),
        .len    (cfg_pulse_len),
        .active (drive)
    );

    rpm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_comb begin
        masked   = drive | (|st_q.guard);
        low_seen = !pin_sync && !masked;

        st_d       = st_q;
        st_d.guard = {st_q.guard[SYNC_STAGES-2:0], drive};
        st_d.evt   = low_seen && cfg_urst_en;
        st_d.cpu_n    = !(drive || st_d.evt);
        st_d.periph_n = !(drive || st_d.evt);
        if (low_seen)     st_d.sticky = 1'b1;
        else if (stat_rd) st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sticky   <= 1'b0;
            st_q.evt      <= 1'b0;
            st_q.cpu_n    <= 1'b0;
            st_q.periph_n <= 1'b0;
            st_q.guard    <= {SYNC_STAGES{1'b1}};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_drive_low = drive;
    assign stat_level    = pin_sync;
    assign stat_sticky   = st_q.sticky;
    assign user_rst_evt  = st_q.evt;
    assign irq           = st_q.sticky && cfg_irq_en;
    assign cpu_rst_n     = st_q.cpu_n;
    assign periph_rst_n  = st_q.periph_n;

    // R10: a driven pad holds both resets on the following edge
    assert_drive_holds_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drive |=> (!cpu_rst_n && !periph_rst_n));
    // R9: own drive never becomes a user reset
    assert_own_drive_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !stat_sticky) |=> (!user_rst_evt && !stat_sticky));
    // R7: a detected low always leaves the flag set, read or not
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        low_seen |=> stat_sticky);
    // R7: a read with no new low clears the flag
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !low_seen) |=> !stat_sticky);
    // R6: disabled user reset produces no event
    assert_disabled_no_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_urst_en |=> !user_rst_evt);
endmodule

// File: tb/sim_rst_pin_mgr.sv
`timescale 1ns/1ps
module sim_rst_pin_mgr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_pulse_len = 4'd1;
    logic       cfg_urst_en = 1'b1;
    logic       cfg_irq_en = 1'b0;
    logic       req_pulse = 1'b0;
    logic       ext_low = 1'b0;
    logic       stat_rd = 1'b0;
    logic       pin_in;
    logic       pin_drive_low, stat_level, stat_sticky, user_rst_evt, irq;
    logic       cpu_rst_n, periph_rst_n;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign pin_in = (pin_drive_low || ext_low) ? 1'b0 : 1'b1;

    rst_pin_mgr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pulse_len(cfg_pulse_len),
        .cfg_urst_en(cfg_urst_en), .cfg_irq_en(cfg_irq_en),
        .req_pulse(req_pulse), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
        .stat_rd(stat_rd), .stat_level(stat_level), .stat_sticky(stat_sticky),
        .user_rst_evt(user_rst_evt), .irq(irq), .cpu_rst_n(cpu_rst_n),
        .periph_rst_n(periph_rst_n)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset_state;
        tick(3);
        chk("R1 drive", pin_drive_low, 1'b1);
        chk("R1 cpu", cpu_rst_n, 1'b0);
        chk("R1 periph", periph_rst_n, 1'b0);
        chk("R1 sticky", stat_sticky, 1'b0);
        chk("R1 evt", user_rst_evt, 1'b0);
    endtask

    task automatic t_powerup;
        rst_n = 1'b1;
        tick(3);
        chk("R2 still driving", pin_drive_low, 1'b1);
        tick(1);
        chk("R2 released", pin_drive_low, 1'b0);
        chk("R10 cpu held one more", cpu_rst_n, 1'b0);
        tick(1);
        chk("R10 cpu released", cpu_rst_n, 1'b1);
        chk("R10 periph released", periph_rst_n, 1'b1);
        tick(4);
        chk("R9 sticky after powerup", stat_sticky, 1'b0);
        chk("R9 evt after powerup", user_rst_evt, 1'b0);
    endtask

    task automatic t_user_reset;
        ext_low = 1'b1;
        tick(1);
        chk("R4 level lag1", stat_level, 1'b1);
        tick(1);
        chk("R4 level lag2", stat_level, 1'b0);
        chk("R5 evt not yet", user_rst_evt, 1'b0);
        tick(1);
        chk("R5 evt", user_rst_evt, 1'b1);
        chk("R5 cpu", cpu_rst_n, 1'b0);
        chk("R5 periph", periph_rst_n, 1'b0);
        chk("R7 sticky set", stat_sticky, 1'b1);
        ext_low = 1'b0;
        tick(3);
        chk("R5 evt ends", user_rst_evt, 1'b0);
        chk("R5 cpu back", cpu_rst_n, 1'b1);
    endtask

    task automatic t_irq_and_read;
        cfg_irq_en = 1'b0;
        #1 chk("R8 irq gated", irq, 1'b0);
        cfg_irq_en = 1'b1;
        #1 chk("R8 irq on", irq, 1'b1);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk("R7 read clears", stat_sticky, 1'b0);
        chk("R8 irq drops", irq, 1'b0);
    endtask

    task automatic t_disabled;
        cfg_urst_en = 1'b0;
        ext_low = 1'b1;
        tick(3);
        chk("R6 no evt", user_rst_evt, 1'b0);
        chk("R6 cpu stays", cpu_rst_n, 1'b1);
        chk("R6 periph stays", periph_rst_n, 1'b1);
        chk("R6 sticky still set", stat_sticky, 1'b1);
        chk("R8 irq on flag", irq, 1'b1);
        ext_low = 1'b0;
        tick(3);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        cfg_urst_en = 1'b1;
    endtask

    task automatic t_collision;
        ext_low = 1'b1;
        tick(2);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk("R7 set wins over read", stat_sticky, 1'b1);
        ext_low = 1'b0;
        tick(3);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk("R7 later read clears", stat_sticky, 1'b0);
    endtask

    task automatic t_request;
        cfg_pulse_len = 4'd2;
        req_pulse = 1'b1;
        tick(1);
        req_pulse = 1'b0;
        chk("R3 drive starts", pin_drive_low, 1'b1);
        tick(1);
        chk("R10 cpu held", cpu_rst_n, 1'b0);
        chk("R10 periph held", periph_rst_n, 1'b0);
        tick(6);
        chk("R3 still driving at 8", pin_drive_low, 1'b1);
        tick(1);
        chk("R3 drive ends", pin_drive_low, 1'b0);
        tick(1);
        chk("R10 cpu back", cpu_rst_n, 1'b1);
        tick(4);
        chk("R9 no sticky from request", stat_sticky, 1'b0);
        chk("R9 no evt from request", user_rst_evt, 1'b0);
    endtask

    task automatic t_retrigger;
        req_pulse = 1'b1;
        tick(1);
        req_pulse = 1'b0;
        tick(3);
        req_pulse = 1'b1;
        tick(1);
        req_pulse = 1'b0;
        tick(7);
        chk("R3 restart extends", pin_drive_low, 1'b1);
        tick(1);
        chk("R3 restart ends", pin_drive_low, 1'b0);
        tick(4);
        chk("R9 no sticky after restart", stat_sticky, 1'b0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_powerup();
        t_user_reset();
        t_irq_and_read();
        t_disabled();
        t_collision();
        t_request();
        t_retrigger();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule